// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block generates the word address stream for the clocked read port of a memory array. A burst begins when the port is selected, write is idle, output enable is inactive and the address-valid strobe is asserted: the start word address and the burst mode are captured on that clock edge. After that, every clock edge that sees the port selected, output enable active, write idle and the strobe released presents one word. The block puts the word's array address on `burst_addr` and raises `data_valid` for that cycle.

There are seven burst kinds. Continuous streaming runs through the whole address space. Fixed lengths of 8, 16 and 32 words come in two forms: one circles inside its aligned block, the other runs straight past the block edge and stops after the programmed count. Deselecting the port or pulling the asynchronous reset low ends a burst. A new address load ends the current burst and arms the next one, and the next clock can already deliver the first word of the new burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, `data_valid` is low and any burst is ended at once, without waiting for a clock; after reset no word is presented until a load.
- R2: A clock edge with `ce_n`=0, `we_n`=1, `oe_n`=1 and `adv_n`=0 is a load. It captures `start_addr` and `mode_sel`, and `data_valid` is low in the cycle that follows.
- R3: A clock edge with `ce_n`=0, `oe_n`=0, `we_n`=1 and `adv_n`=1, while a burst is armed, is an advance. After it, `data_valid` is 1 and `burst_addr` shows the current word. The first word of a burst is the loaded start address.
- R4: `mode_sel` 0 and 7 select continuous mode. Each word is the previous word plus one across the full address width, rolling from all-ones to zero, and the burst has no length limit.
- R5: `mode_sel` 1, 2 and 3 select wrapping bursts of 8, 16 and 32 words. Only the low 3, 4 or 5 address bits count, modulo the length, and the upper bits stay those of the start address; for example, 0x0D in 8-word mode gives 0D 0E 0F 08 09 0A 0B 0C 0D. The burst does not end by itself.
- R6: `mode_sel` 4, 5 and 6 select linear bursts of 8, 16 and 32 words. The full address counts up from the start, and after exactly that many words the burst ends: further advance edges leave `data_valid` low until the next load.
- R7: An edge with `oe_n`=1 and no load presents no word and does not move the address. The next advance continues with the word that follows the last one presented.
- R8: An edge with `ce_n`=1 ends the burst. `data_valid` is low afterwards, and later advance edges present nothing until a new load.
- R9: A load during an active burst ends it and arms a new burst at the new address. An advance on the very next edge presents the new start address.
- R10: An edge with `ce_n`=0 that is neither a load nor an advance (`we_n`=0, or `adv_n`=0 together with `oe_n`=0) presents no word and leaves the burst position unchanged.
- R11: Changes on `mode_sel` after a load have no effect on the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Asynchronous reset, active low; ends any burst |
| ce_n | input | 1 | Port select, active low |
| oe_n | input | 1 | Output enable, active low; low requests the next word |
| we_n | input | 1 | Write enable, active low; must be high for loads and advances |
| adv_n | input | 1 | Address-valid strobe, active low |
| mode_sel | input | 3 | Burst kind, captured at load (encoding in R4 to R6) |
| start_addr | input | AW | Burst start word address, captured at load |
| burst_addr | output | AW | Array address of the word presented this cycle |
| data_valid | output | 1 | High for one cycle per presented word |

## Verification
The bench builds the block with `AW` = 8. The whole space is then 256 words, or eight 32-word blocks, so random start addresses often land near block edges. Continuous bursts roll over from 0xFF to 0x00 within a handful of words, and linear bursts regularly cross block boundaries. The 8-bit width also lets directed cases pin the exact rollover and wrap points without long runs.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    // Upper bound on log2 of the fixed burst lengths (32 words).
    localparam int unsigned MAX_LOG = 5;

    typedef enum logic [2:0] {
        BM_STREAM    = 3'd0,
        BM_CIRC8     = 3'd1,
        BM_CIRC16    = 3'd2,
        BM_CIRC32    = 3'd3,
        BM_RUN8      = 3'd4,
        BM_RUN16     = 3'd5,
        BM_RUN32     = 3'd6,
        BM_STREAM_B  = 3'd7
    } burst_mode_e;

endpackage

// File: rtl/bsq_cmd_decode.sv
module bsq_cmd_decode (
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic adv_n,
    output logic sel_off,
    output logic do_load,
    output logic do_step
);
    always_comb begin
        sel_off = ce_n;
        do_load = !ce_n && we_n && !adv_n && oe_n;
        do_step = !ce_n && we_n && adv_n && !oe_n;
    end

    always_comb begin
        a_excl_r10: assert (!(do_load && do_step) && !(sel_off && (do_load || do_step)));
    end
endmodule

// File: rtl/bsq_mode_decode.sv
module bsq_mode_decode
    import bsq_pkg::*;
(
    input  burst_mode_e             mode,
    output logic                    circ,
    output logic                    limited,
    output logic [MAX_LOG-1:0]      low_mask,
    output logic [MAX_LOG:0]        length
);
    always_comb begin
        circ     = 1'b0;
        limited  = 1'b0;
        low_mask = '0;
        length   = '0;
        unique case (mode)
            BM_CIRC8:  begin circ = 1'b1; low_mask = 5'h07; length = 6'd8;  end
            BM_CIRC16: begin circ = 1'b1; low_mask = 5'h0F; length = 6'd16; end
            BM_CIRC32: begin circ = 1'b1; low_mask = 5'h1F; length = 6'd32; end
            BM_RUN8:   begin limited = 1'b1; length = 6'd8;  end
            BM_RUN16:  begin limited = 1'b1; length = 6'd16; end
            BM_RUN32:  begin limited = 1'b1; length = 6'd32; end
            default:   begin end
        endcase
    end
endmodule

// File: rtl/bsq_addr_step.sv
module bsq_addr_step
    import bsq_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0]      cur,
    input  logic               circ,
    input  logic [MAX_LOG-1:0] low_mask,
    output logic [AW-1:0]      nxt
);
    localparam int unsigned PAD = AW - MAX_LOG;

    logic [AW-1:0] mask_full;
    logic [AW-1:0] inc;

    always_comb begin
        mask_full = {{PAD{1'b0}}, low_mask};
        inc       = cur + AW'(1);
        if (circ) begin
            nxt = (cur & ~mask_full) | (inc & mask_full);
        end else begin
            nxt = inc;
        end
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bsq_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          adv_n,
    input  logic [2:0]    mode_sel,
    input  logic [AW-1:0] start_addr,
    output logic [AW-1:0] burst_addr,
    output logic          data_valid
);
    localparam int unsigned CW = MAX_LOG + 1;

    typedef struct packed {
        logic          armed;
        burst_mode_e   mode;
        logic [AW-1:0] ptr;
        logic [CW-1:0] cnt;
        logic [AW-1:0] word;
        logic          valid;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic               sel_off, do_load, do_step;
    logic               circ, limited;
    logic [MAX_LOG-1:0] low_mask;
    logic [MAX_LOG:0]   length;
    logic [AW-1:0]      ptr_nxt;

    bsq_cmd_decode u_cmd (
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .adv_n   (adv_n),
        .sel_off (sel_off),
        .do_load (do_load),
        .do_step (do_step)
    );

    bsq_mode_decode u_mode (
        .mode     (s_q.mode),
        .circ     (circ),
        .limited  (limited),
        .low_mask (low_mask),
        .length   (length)
    );

    bsq_addr_step #(.AW(AW)) u_step (
        .cur      (s_q.ptr),
        .circ     (circ),
        .low_mask (low_mask),
        .nxt      (ptr_nxt)
    );

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        if (sel_off) begin
            s_d.armed = 1'b0;
        end else if (do_load) begin
            s_d.armed = 1'b1;
            s_d.mode  = burst_mode_e'(mode_sel);
            s_d.ptr   = start_addr;
            s_d.cnt   = '0;
        end else if (do_step && s_q.armed) begin
            s_d.word  = s_q.ptr;
            s_d.valid = 1'b1;
            s_d.ptr   = ptr_nxt;
            if (limited) begin
                s_d.cnt = s_q.cnt + CW'(1);
                if (s_q.cnt == (length - CW'(1))) begin
                    s_d.armed = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{armed: 1'b0, mode: BM_STREAM, ptr: '0, cnt: '0, word: '0, valid: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign burst_addr = s_q.word;
    assign data_valid = s_q.valid;

    // A load edge never presents a word.
    p_load_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> !data_valid);

    // Deselect always ends output.
    p_deselect_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !data_valid);

    // A presented word needs an advance edge before it.
    p_word_needs_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> $past(!ce_n && !oe_n && we_n && adv_n));

    // Back-to-back words in a circular burst keep the upper address bits.
    p_circ_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && $past(data_valid) && circ) |->
        ((burst_addr >> MAX_LOG) == ($past(burst_addr) >> MAX_LOG)));

    // Back-to-back words in non-circular bursts step by one.
    p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && $past(data_valid) && !circ) |->
        (burst_addr == $past(burst_addr) + AW'(1)));

    // A limited burst never counts past its length.
    p_len_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.armed && limited) |-> (s_q.cnt < CW'(length)));

    // Mode is frozen between loads.
    p_mode_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(do_load) |-> $stable(s_q.mode));

endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
    localparam int unsigned AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, adv_n = 1'b1;
    logic [2:0]    mode_sel = 3'd0;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] burst_addr;
    logic          data_valid;

    int checks = 0;
    int errors = 0;

    // reference state
    logic          m_armed = 1'b0;
    logic [2:0]    m_mode = 3'd0;
    logic [AW-1:0] m_ptr = '0;
    int            m_cnt = 0;
    logic          e_valid = 1'b0;
    logic [AW-1:0] e_addr = '0;
    string         tag = "R1";
    string         end_tag = "R1";

    always #2.5 clk = ~clk;

    burst_addr_seq #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .adv_n(adv_n), .mode_sel(mode_sel), .start_addr(start_addr),
        .burst_addr(burst_addr), .data_valid(data_valid)
    );

    function automatic int blen(input logic [2:0] m);
        case (m)
            3'd1, 3'd4: return 8;
            3'd2, 3'd5: return 16;
            3'd3, 3'd6: return 32;
            default:    return 0;
        endcase
    endfunction

    function automatic logic [AW-1:0] next_word(input logic [2:0] m, input logic [AW-1:0] a);
        int n;
        logic [AW-1:0] msk;
        n = blen(m);
        if (m >= 3'd1 && m <= 3'd3) begin
            msk = AW'(n - 1);
            return (a & ~msk) | ((a + AW'(1)) & msk);
        end
        return a + AW'(1);
    endfunction

    function automatic string mode_tag(input logic [2:0] m);
        if (m >= 3'd1 && m <= 3'd3) return "R5";
        if (m >= 3'd4 && m <= 3'd6) return "R6";
        return "R4";
    endfunction

    task automatic check(input string req, input logic [AW:0] act, input logic [AW:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model(input logic c, input logic o, input logic w, input logic a,
                         input logic [2:0] m, input logic [AW-1:0] s);
        e_valid = 1'b0;
        if (c) begin
            m_armed = 1'b0; tag = "R8"; end_tag = "R8";
        end else if (w && !a && o) begin
            tag = m_armed ? "R9" : "R2";
            m_armed = 1'b1; m_mode = m; m_ptr = s; m_cnt = 0;
        end else if (w && a && !o) begin
            if (m_armed) begin
                e_valid = 1'b1; e_addr = m_ptr; tag = mode_tag(m_mode);
                m_ptr = next_word(m_mode, m_ptr);
                if (m_mode >= 3'd4 && m_mode <= 3'd6) begin
                    m_cnt++;
                    if (m_cnt == blen(m_mode)) begin m_armed = 1'b0; end_tag = "R6"; end
                end
            end else begin
                tag = end_tag;
            end
        end else begin
            tag = o ? "R7" : "R10";
        end
    endtask

    task automatic cyc(input logic c, input logic o, input logic w, input logic a,
                       input logic [2:0] m, input logic [AW-1:0] s, input string force_tag);
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w; adv_n = a; mode_sel = m; start_addr = s;
        model(c, o, w, a, m, s);
        if (force_tag != "") tag = force_tag;
        @(posedge clk);
        #1;
        check(tag, {AW'(0), data_valid}, {AW'(0), e_valid});
        if (e_valid) check(tag, {1'b0, burst_addr}, {1'b0, e_addr});
    endtask

    task automatic load(input logic [2:0] m, input logic [AW-1:0] s);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, m, s, "");
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1, 1'b1, 3'd0, '0, "");
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1", {AW'(0), data_valid}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        step(2); // R1: nothing before a load

        // R5: 0x0D in 8-word circular mode
        load(3'd1, 8'h0D);
        step(9);
        // R7: pause then continue
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 3'd0, '0, "R7");
        step(2);
        // R10: write low and strobe low with oe low
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 3'd0, '0, "R10");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 3'd0, '0, "R10");
        step(1);
        // R8: deselect ends burst
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 3'd0, '0, "R8");
        step(2);
        // R4: continuous rollover, both encodings
        load(3'd0, 8'hFD); step(5);
        load(3'd7, 8'hFF); step(3);
        // R6: linear 8 crossing a block edge, then ignored steps
        load(3'd4, 8'h7C); step(10);
        load(3'd6, 8'hF0); step(34);
        // R5: 32-word wrap from unaligned start
        load(3'd3, 8'h5E); step(35);
        // R9: restart with no idle cycle
        load(3'd2, 8'h20); step(3);
        load(3'd5, 8'h3B); step(4);
        // R11: mode input changes mid-burst
        load(3'd1, 8'h44);
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 1'b1, 1'b1, 3'(i + 2), '0, "R11");
        // R1: asynchronous reset mid-burst
        load(3'd0, 8'h10); step(2);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", {AW'(0), data_valid}, '0);
        m_armed = 1'b0; end_tag = "R1";
        @(negedge clk);
        rst_n = 1'b1;
        step(2);

        // random traffic
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = int'($urandom % 16);
            if (r == 0)       cyc(1'b1, 1'($urandom), 1'b1, 1'($urandom), 3'($urandom), 8'($urandom), "");
            else if (r == 1)  cyc(1'b0, 1'($urandom), 1'b0, 1'($urandom), 3'($urandom), 8'($urandom), "");
            else if (r <= 3)  cyc(1'b0, 1'b1, 1'b1, 1'b1, 3'($urandom), 8'($urandom), "");
            else if (r <= 5)  cyc(1'b0, 1'b1, 1'b1, 1'b0, 3'($urandom), 8'($urandom), "");
            else              cyc(1'b0, 1'b0, 1'b1, 1'b1, 3'($urandom), 8'($urandom), "");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule